// File: doc/BRIEF.md
# Tournament Hybrid Branch Predictor

This block predicts the direction of conditional branches by running two direction predictors side by side and letting a third table pick between them for each branch. The first component is a global-history predictor. A shift register holds the outcomes of the most recent resolved branches. That register is XORed with the low bits of the branch address, and the result indexes one shared table of 2-bit counters. The second component is a plain per-address table of 2-bit counters, indexed by the low address bits. A chooser table of 2-bit up/down counters, indexed by the same low address bits, decides which of the two predictions is used.

The fetch side presents a branch address on `pred_pc`. In the same cycle, with no register in the path, it gets the chosen direction, both component directions and both table indices. It keeps these values as a snapshot. When the branch resolves, the pipeline returns the snapshot and the real outcome on the resolve port. On the next clock edge, both component counters and the chooser counter are updated and the outcome is shifted into the history register.

Every 2-bit counter is a small state machine with four states: SNT (00), WNT (01), WT (10) and ST (11). The transition "up" moves SNT→WNT→WT→ST and holds in ST. The transition "down" moves ST→WT→WNT→SNT and holds in SNT. The transition "hold" keeps the current state.

Top module: `tournament_predictor`

## Requirements
- R1: After reset, every counter in all three tables is in WNT (01) and the history register is all zero. As a result, `pred_gidx` equals the low GHIST_W address bits, both component predictions are not-taken, and the local component is chosen.
- R2: `pred_gidx` is the bitwise XOR of the GHIST_W-bit history register and `pred_pc[GHIST_W-1:0]`.
- R3: `pred_lidx` is `pred_pc[LOCAL_W-1:0]`. This value indexes both the local component table and the chooser table.
- R4: A component counter moves up on a taken outcome and down on a not-taken outcome. It saturates at 00 and 11, and its prediction is its high bit (1 means taken).
- R5: On every resolve, both component counters are trained: the global counter at `res_gidx` and the local counter at `res_lidx`. This happens whichever component was chosen.
- R6: When the chooser counter at `pred_lidx` is 10 or 11, `pred_use_global` is 1 and `pred_taken` follows the global component. When the counter is 00 or 01, `pred_use_global` is 0 and `pred_taken` follows the local component.
- R7: On a resolve where the global component was right and the local component was wrong, the chooser counter at `res_lidx` moves up. Where the global component was wrong and the local component was right, it moves down. Both moves saturate at 00 and 11.
- R8: When both components were right, or both were wrong, the chooser counter stays unchanged.
- R9: Each resolve shifts the history register left by one, with `res_taken` entering bit 0. Without a resolve, the history register keeps its value.
- R10: Correctness is judged by comparing `res_global_pred` and `res_local_pred` against `res_taken`. The current contents of the tables are not used for this comparison.
- R11: A lookup in the same cycle as a resolve that writes the same entry returns the value from before the update. The updated value appears from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pred_pc | input | PC_W | Address of the branch being looked up |
| pred_taken | output | 1 | Final predicted direction |
| pred_use_global | output | 1 | 1 when the global component is chosen |
| pred_global_taken | output | 1 | Direction from the global component |
| pred_local_taken | output | 1 | Direction from the local component |
| pred_gidx | output | GHIST_W | Global table index snapshot |
| pred_lidx | output | LOCAL_W | Local/chooser index snapshot |
| res_valid | input | 1 | A branch resolves this cycle |
| res_taken | input | 1 | Actual outcome of the resolving branch |
| res_gidx | input | GHIST_W | Global index snapshot of the resolving branch |
| res_lidx | input | LOCAL_W | Local/chooser index snapshot of the resolving branch |
| res_global_pred | input | 1 | Global component prediction made for that branch |
| res_local_pred | input | 1 | Local component prediction made for that branch |

## Verification
The bench first runs a single branch address through a long taken run and then a long not-taken run. This separates correct saturation from wrap-around in the component counters. It then uses alternating outcomes and a correlated pattern spread over several addresses. These move the history register and show whether the XOR index and the shift direction are right, because the global and local components then disagree.

Crafted resolves with chosen snapshot predictions exercise each branch of the chooser update separately: global-only right, local-only right, both right and both wrong. One pattern supplies snapshot predictions that conflict with the current table contents, which shows that the chooser follows the supplied snapshots. Several steps look up the same entry that is being written in that cycle, which shows the old-value-then-new-value timing.

// File: rtl/tp_pkg.sv
package tp_pkg;

    // Two-bit counter states; the high bit is the predicted direction.
    typedef enum logic [1:0] {
        CTR_SNT = 2'b00,
        CTR_WNT = 2'b01,
        CTR_WT  = 2'b10,
        CTR_ST  = 2'b11
    } ctr_state_e;

    typedef enum logic [1:0] {
        OP_HOLD = 2'b00,
        OP_UP   = 2'b01,
        OP_DOWN = 2'b10
    } ctr_op_e;

    function automatic ctr_state_e ctr_step(ctr_state_e cur, ctr_op_e op);
        ctr_state_e nxt;
        nxt = cur;
        case (op)
            OP_UP: begin
                unique case (cur)
                    CTR_SNT: nxt = CTR_WNT;
                    CTR_WNT: nxt = CTR_WT;
                    CTR_WT:  nxt = CTR_ST;
                    CTR_ST:  nxt = CTR_ST;
                endcase
            end
            OP_DOWN: begin
                unique case (cur)
                    CTR_SNT: nxt = CTR_SNT;
                    CTR_WNT: nxt = CTR_SNT;
                    CTR_WT:  nxt = CTR_WNT;
                    CTR_ST:  nxt = CTR_WT;
                endcase
            end
            default: nxt = cur;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/tp_ctr_table.sv
module tp_ctr_table
    import tp_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output ctr_state_e       rd_state,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  ctr_op_e          wr_op
);

    localparam int DEPTH = 1 << IDX_W;

    ctr_state_e tbl [DEPTH];

    // State register process: every entry is its own counter FSM.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                tbl[i] <= CTR_WNT;
            end
        end else if (wr_en) begin
            tbl[wr_idx] <= ctr_step(tbl[wr_idx], wr_op);
        end
    end

    // Output process: lookup returns the pre-update state (R11).
    always_comb begin
        rd_state = tbl[rd_idx];
    end

    // R4 / R7: saturation at the top
    a_r4_sat_top: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_op == OP_UP && tbl[wr_idx] == CTR_ST)
        |=> tbl[$past(wr_idx)] == CTR_ST);

    // R4 / R7: saturation at the bottom
    a_r4_sat_bottom: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_op == OP_DOWN && tbl[wr_idx] == CTR_SNT)
        |=> tbl[$past(wr_idx)] == CTR_SNT);

    // R4 / R7: one step up below the top
    a_r4_step_up: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_op == OP_UP && tbl[wr_idx] != CTR_ST)
        |=> 2'(tbl[$past(wr_idx)]) == 2'(2'($past(tbl[wr_idx])) + 2'd1));

    // R8: a hold update leaves the entry untouched
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_op == OP_HOLD)
        |=> tbl[$past(wr_idx)] == $past(tbl[wr_idx]));

endmodule

// File: rtl/tp_ghist.sv
module tp_ghist #(
    parameter int HIST_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              shift_bit,
    output logic [HIST_W-1:0] hist
);

    logic [HIST_W-1:0] hist_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else if (shift_en) begin
            hist_q <= {hist_q[HIST_W-2:0], shift_bit};
        end
    end

    always_comb begin
        hist = hist_q;
    end

    // R9: newest outcome lands in bit 0, older bits move up
    a_r9_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (hist_q[0] == $past(shift_bit))
                  && (hist_q[HIST_W-1:1] == $past(hist_q[HIST_W-2:0])));

    // R9: no resolve, no change
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(hist_q));

endmodule

// File: rtl/tournament_predictor.sv
module tournament_predictor
    import tp_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int GHIST_W = 6,
    parameter int LOCAL_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PC_W-1:0]    pred_pc,
    output logic               pred_taken,
    output logic               pred_use_global,
    output logic               pred_global_taken,
    output logic               pred_local_taken,
    output logic [GHIST_W-1:0] pred_gidx,
    output logic [LOCAL_W-1:0] pred_lidx,
    input  logic               res_valid,
    input  logic               res_taken,
    input  logic [GHIST_W-1:0] res_gidx,
    input  logic [LOCAL_W-1:0] res_lidx,
    input  logic               res_global_pred,
    input  logic               res_local_pred
);

    logic [GHIST_W-1:0] hist;
    logic [GHIST_W-1:0] look_gidx;
    logic [LOCAL_W-1:0] look_lidx;
    ctr_state_e         g_state;
    ctr_state_e         l_state;
    ctr_state_e         s_state;
    ctr_op_e            comp_op;
    ctr_op_e            sel_op;
    logic               g_right;
    logic               l_right;

    // R2 / R3: index formation
    always_comb begin
        look_gidx = hist ^ pred_pc[GHIST_W-1:0];
        look_lidx = pred_pc[LOCAL_W-1:0];
    end

    // R4 / R5: both components always trained toward the outcome
    always_comb begin
        comp_op = res_taken ? OP_UP : OP_DOWN;
    end

    // R7 / R8 / R10: chooser move from the snapshot predictions
    always_comb begin
        g_right = (res_global_pred == res_taken);
        l_right = (res_local_pred  == res_taken);
        unique case ({g_right, l_right})
            2'b10:   sel_op = OP_UP;
            2'b01:   sel_op = OP_DOWN;
            default: sel_op = OP_HOLD;
        endcase
    end

    tp_ghist #(.HIST_W(GHIST_W)) i_hist (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (res_valid),
        .shift_bit (res_taken),
        .hist      (hist)
    );

    tp_ctr_table #(.IDX_W(GHIST_W)) i_global (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (look_gidx),
        .rd_state (g_state),
        .wr_en    (res_valid),
        .wr_idx   (res_gidx),
        .wr_op    (comp_op)
    );

    tp_ctr_table #(.IDX_W(LOCAL_W)) i_local (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (look_lidx),
        .rd_state (l_state),
        .wr_en    (res_valid),
        .wr_idx   (res_lidx),
        .wr_op    (comp_op)
    );

    tp_ctr_table #(.IDX_W(LOCAL_W)) i_chooser (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (look_lidx),
        .rd_state (s_state),
        .wr_en    (res_valid),
        .wr_idx   (res_lidx),
        .wr_op    (sel_op)
    );

    // R6: output selection
    always_comb begin
        pred_gidx         = look_gidx;
        pred_lidx         = look_lidx;
        pred_global_taken = g_state[1];
        pred_local_taken  = l_state[1];
        pred_use_global   = s_state[1];
        pred_taken        = s_state[1] ? g_state[1] : l_state[1];
    end

endmodule

// File: tb/test_tournament_predictor.sv
`timescale 1ns/1ps
module test_tournament_predictor;

    localparam int PC_W = 32;
    localparam int K    = 6;
    localparam int N    = 6;
    localparam int KM   = (1 << K) - 1;
    localparam int NM   = (1 << N) - 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [PC_W-1:0] pred_pc = '0;
    logic            pred_taken, pred_use_global, pred_global_taken, pred_local_taken;
    logic [K-1:0]    pred_gidx;
    logic [N-1:0]    pred_lidx;
    logic            res_valid = 1'b0, res_taken = 1'b0;
    logic [K-1:0]    res_gidx = '0;
    logic [N-1:0]    res_lidx = '0;
    logic            res_global_pred = 1'b0, res_local_pred = 1'b0;

    always #2.5 clk = ~clk;

    tournament_predictor #(.PC_W(PC_W), .GHIST_W(K), .LOCAL_W(N)) i_tournament_predictor (
        .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(pred_taken),
        .pred_use_global(pred_use_global), .pred_global_taken(pred_global_taken),
        .pred_local_taken(pred_local_taken), .pred_gidx(pred_gidx), .pred_lidx(pred_lidx),
        .res_valid(res_valid), .res_taken(res_taken), .res_gidx(res_gidx),
        .res_lidx(res_lidx), .res_global_pred(res_global_pred), .res_local_pred(res_local_pred)
    );

    int gm [1 << K];
    int lm [1 << N];
    int sm [1 << N];
    int mhist;
    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int sat(input int v, input bit up);
        if (up) return (v < 3) ? v + 1 : 3;
        return (v > 0) ? v - 1 : 0;
    endfunction

    // One clock: drive, compare every output with the model, then advance the model.
    task automatic step(input int pc, input bit rv, input bit rt, input int rgi,
                        input int rli, input bit rgp, input bit rlp, input string tag);
        int egi, eli, eg, el, eu;
        @(negedge clk);
        pred_pc = PC_W'(pc);
        res_valid = rv; res_taken = rt;
        res_gidx = K'(rgi); res_lidx = N'(rli);
        res_global_pred = rgp; res_local_pred = rlp;
        #1;
        egi = (mhist ^ pc) & KM;
        eli = pc & NM;
        eg = (gm[egi] >= 2) ? 1 : 0;
        el = (lm[eli] >= 2) ? 1 : 0;
        eu = (sm[eli] >= 2) ? 1 : 0;
        chk(tag, "gidx(R2)", int'(pred_gidx), egi);
        chk(tag, "lidx(R3)", int'(pred_lidx), eli);
        chk(tag, "global_taken(R4)", int'(pred_global_taken), eg);
        chk(tag, "local_taken(R5)", int'(pred_local_taken), el);
        chk(tag, "use_global(R7)", int'(pred_use_global), eu);
        chk(tag, "taken(R6)", int'(pred_taken), eu ? eg : el);
        @(posedge clk);
        if (rv) begin
            gm[rgi & KM] = sat(gm[rgi & KM], rt);
            lm[rli & NM] = sat(lm[rli & NM], rt);
            if (rgp == rt && rlp != rt) sm[rli & NM] = sat(sm[rli & NM], 1);
            else if (rgp != rt && rlp == rt) sm[rli & NM] = sat(sm[rli & NM], 0);
            mhist = ((mhist << 1) | int'(rt)) & KM;
        end
    endtask

    // Look up and resolve a branch in the same cycle, using the model's snapshot.
    task automatic branch(input int pc, input bit rt, input string tag);
        int gi, li;
        gi = (mhist ^ pc) & KM;
        li = pc & NM;
        step(pc, 1'b1, rt, gi, li, gm[gi] >= 2, lm[li] >= 2, tag);
    endtask

    task automatic idle(input int pc, input string tag);
        step(pc, 1'b0, 1'b0, 0, 0, 1'b0, 1'b0, tag);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i <= KM; i++) gm[i] = 1;
        for (int i = 0; i <= NM; i++) begin lm[i] = 1; sm[i] = 1; end
        mhist = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state across several addresses
        idle(0, "R1"); idle(5, "R1"); idle(63, "R1"); idle(32'h1234_5677, "R1");

        // R4: saturation up then down at one address (lookup of same entry, R11)
        for (int i = 0; i < 5; i++) branch(32'h40, 1'b1, "R4");
        for (int i = 0; i < 6; i++) branch(32'h40, 1'b0, "R4");
        idle(32'h40, "R11");

        // R9 / R2: history motion changes the global index
        branch(3, 1'b1, "R9"); branch(7, 1'b0, "R9"); branch(9, 1'b1, "R9");
        idle(3, "R9"); idle(3, "R9");

        // R5: training of both components regardless of choice
        for (int i = 0; i < 8; i++) branch(32'h11 + (i % 2), i[0], "R5");

        // R7: global right, local wrong -> chooser up, saturate
        for (int i = 0; i < 4; i++) step(20, 1'b1, 1'b1, 20, 20, 1'b1, 1'b0, "R7");
        idle(20, "R7");
        // R7: global wrong, local right -> chooser down, saturate
        for (int i = 0; i < 5; i++) step(21, 1'b1, 1'b0, 21, 21, 1'b1, 1'b0, "R7");
        idle(21, "R7");

        // R8: from WT, both right and both wrong keep the choice
        step(22, 1'b1, 1'b1, 22, 22, 1'b1, 1'b0, "R8");
        step(22, 1'b1, 1'b1, 22, 22, 1'b1, 1'b1, "R8");
        step(22, 1'b1, 1'b0, 22, 22, 1'b1, 1'b1, "R8");
        idle(22, "R8");

        // R10: snapshot predictions contradict table contents
        step(30, 1'b1, 1'b1, 5, 30, 1'b1, 1'b0, "R10");
        step(30, 1'b1, 1'b1, 5, 30, 1'b1, 1'b0, "R10");
        idle(30, "R10");

        // R6: correlated pattern over several addresses, chooser drifts
        for (int i = 0; i < 60; i++) branch(8 + (i % 3), (i % 3) == 2 ? 1'b1 : (i % 5 == 0), "R6");

        // R3: wide addresses alias on low bits
        idle(32'hFFFF_FFC8, "R3"); idle(32'h0000_0108, "R3");

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule